// File: doc/BRIEF.md
# Function Event Queue Controller

This block holds a first-in first-out queue of pending function events for a small set of I/O function slots. It also keeps the per-slot state that these events describe. An event is either an error report or an availability change. An error report is pushed from an internal request port with its own handle, id, fault address, qualifier word and status code. Availability events are produced by the block itself whenever a slot is plugged or unplugged. Every event that enters the queue produces a one-cycle notification pulse toward the host side.

A consumer sees a pending flag and asks for one record per request. The oldest record comes back on the record outputs one cycle later. The same slot table answers configure and deconfigure commands addressed by function id, and each command produces a response code. A slot's function id is its slot number. Its handle is the slot number with the top handle bit set, and a slot with a zero handle counts as empty.

Top module: `func_event_queue`

## Requirements
- R1: Records leave in the order they entered. Each pop request made while `evtPending` is high returns the oldest record. `evtPending` is high exactly when at least one record is held.
- R2: An error push queues one record of class 1 (popClass = 1) that carries the pushed status, handle, id, fault address and qualifier unchanged.
- R3: An availability record has class 2 (popClass = 2) and carries a status, a handle and an id. Its fault address and qualifier fields read as zero.
- R4: `notifyPulse` is high for one cycle, the cycle after a cycle in which at least one record was queued. It stays low when every record of a request is dropped.
- R5: A plug request queues two availability records, status 0x0301 and then status 0x0302. Both carry handle = slot | 0x8000_0000 and id = slot. The slot becomes populated and configured.
- R6: An unplug request on a configured slot queues status 0x0303 and then status 0x0304, both with the slot's current handle and id. The slot is then left unpopulated and unconfigured.
- R7: An unplug request on a slot that is not configured queues only status 0x0304, with the slot's current handle and id. These are zero when the slot is unpopulated.
- R8: A configure (`cfgOn` = 1) or deconfigure (`cfgOn` = 0) command on a populated slot that is already in the requested state answers code 1 (no action) and changes nothing.
- R9: A configure or deconfigure command on a populated slot in the other state flips its configured state and answers code 0 (normal completion).
- R10: A command whose `cfgId` matches no populated slot answers code 2 (id not recognized). Every command's response appears with `cfgRespValid` one cycle after `cfgReq`.
- R11: The queue holds 16 records. A record that finds the queue full is dropped and sets `overflowFlag`, which stays set until reset. If a two-record request finds one free place, the first record is kept and the second is dropped. Fullness is judged before a pop in the same cycle.
- R12: A pop request on an empty queue returns `popValid` with popClass = 0 and all other record fields zero, and leaves the queue and flags unchanged.
- R13: When several requests arrive in one cycle, only one is honoured: unplug first, then plug, then error push. The others are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errPush | input | 1 | Queue one error record |
| errStatus | input | 16 | Error status code |
| errHandle | input | 32 | Error function handle |
| errId | input | 32 | Error function id |
| errAddr | input | 64 | Error fault address |
| errQual | input | 32 | Error qualifier word |
| plugReq | input | 1 | Plug the slot on hpSlot |
| unplugReq | input | 1 | Unplug the slot on hpSlot |
| hpSlot | input | 3 | Slot addressed by plug/unplug |
| cfgReq | input | 1 | Configure/deconfigure command strobe |
| cfgOn | input | 1 | 1 = configure, 0 = deconfigure |
| cfgId | input | 32 | Function id addressed by the command |
| cfgRespValid | output | 1 | Command response strobe |
| cfgResp | output | 2 | 0 normal, 1 no action, 2 id not recognized |
| popReq | input | 1 | Take the oldest record |
| evtPending | output | 1 | At least one record held |
| popValid | output | 1 | Record outputs valid |
| popClass | output | 2 | 0 none, 1 error, 2 availability |
| popStatus | output | 16 | Record status code |
| popHandle | output | 32 | Record function handle |
| popId | output | 32 | Record function id |
| popAddr | output | 64 | Record fault address |
| popQual | output | 32 | Record qualifier word |
| notifyPulse | output | 1 | A record was queued last cycle |
| overflowFlag | output | 1 | Sticky record-dropped flag |

## Verification
A push, plug or unplug sampled at one clock edge is in the queue right after that edge. `evtPending` changes then as well, and `notifyPulse` follows from the same edge. A pop or configure command sampled at an edge presents its record or response right after that edge and holds it for exactly one cycle. The bench drives every request on a falling edge. It reads the results on the next falling edge, after exactly one rising edge has passed, and clears the request at that same point. No check samples at a clock edge.

// File: rtl/fevq_pkg.sv
package fevq_pkg;
  localparam int HANDLE_W = 32;
  localparam int ID_W     = 32;
  localparam int ADDR_W   = 64;
  localparam int QUAL_W   = 32;
  localparam int STATUS_W = 16;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ERR   = 2'd1,
    CLS_AVAIL = 2'd2
  } evClass_t;

  typedef enum logic [1:0] {
    RSP_NORMAL  = 2'd0,
    RSP_NOACT   = 2'd1,
    RSP_UNKNOWN = 2'd2
  } cfgResp_t;

  // availability status codes, in the order a full plug/unplug cycle emits them
  localparam logic [STATUS_W-1:0] ST_RES_TO_STBY = 16'h0301;
  localparam logic [STATUS_W-1:0] ST_STBY_TO_CFG = 16'h0302;
  localparam logic [STATUS_W-1:0] ST_CFG_TO_STBY = 16'h0303;
  localparam logic [STATUS_W-1:0] ST_STBY_TO_RES = 16'h0304;

  typedef struct packed {
    evClass_t              cls;
    logic [STATUS_W-1:0]   status;
    logic [HANDLE_W-1:0]   handle;
    logic [ID_W-1:0]       id;
    logic [ADDR_W-1:0]     addr;
    logic [QUAL_W-1:0]     qual;
  } evRec_t;

  // strobes from control to datapath; wr1 is only ever raised together with wr0
  typedef struct packed {
    logic wr0;
    logic wr1;
    logic rd;
  } qStrobe_t;
endpackage

// File: rtl/fevq_datapath.sv
module fevq_datapath
  import fevq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  qStrobe_t stb,
  input  evRec_t   ent0,
  input  evRec_t   ent1,
  output logic     evtPending,
  output logic     popValid,
  output evRec_t   popRec,
  output logic     notifyPulse,
  output logic     overflowFlag
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  evRec_t             mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr, wrPtrNext;
  logic [CNT_W-1:0]   count, freeSlots, nWr;
  logic               acc0, acc1, doPop, dropAny;

  assign freeSlots  = CNT_W'(DEPTH) - count;
  assign acc0       = stb.wr0 && (freeSlots != '0);
  assign acc1       = stb.wr1 && (freeSlots >= CNT_W'(2));
  assign dropAny    = (stb.wr0 && !acc0) || (stb.wr1 && !acc1);
  assign doPop      = stb.rd && (count != '0);
  assign nWr        = CNT_W'(acc0) + CNT_W'(acc1);
  assign wrPtrNext  = wrPtr + PTR_W'(1);
  assign evtPending = (count != '0);

  always_ff @(posedge clk) begin
    if (acc0) mem[wrPtr] <= ent0;
    if (acc1) mem[wrPtrNext] <= ent1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count        <= '0;
      wrPtr        <= '0;
      rdPtr        <= '0;
      popValid     <= 1'b0;
      popRec       <= '0;
      notifyPulse  <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      wrPtr       <= wrPtr + PTR_W'(nWr);
      rdPtr       <= rdPtr + PTR_W'(doPop);
      count       <= count + nWr - CNT_W'(doPop);
      popValid    <= stb.rd;
      popRec      <= doPop ? mem[rdPtr] : '0;
      notifyPulse <= acc0 || acc1;
      if (dropAny) overflowFlag <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)) else $error("count above depth"); // R11

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag) else $error("overflow cleared"); // R11

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && count == '0) |=> (popValid && popRec.cls == CLS_NONE))
    else $error("empty pop returned a record"); // R12

  AST_EMPTY_POP_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && count == '0 && !stb.wr0) |=> ($stable(count) && $stable(rdPtr)))
    else $error("empty pop changed state"); // R12

  AST_NOTIFY_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    (count > $past(count)) |-> notifyPulse) else $error("growth without notify"); // R4
endmodule

// File: rtl/fevq_control.sv
module fevq_control
  import fevq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 errPush,
  input  logic [STATUS_W-1:0]  errStatus,
  input  logic [HANDLE_W-1:0]  errHandle,
  input  logic [ID_W-1:0]      errId,
  input  logic [ADDR_W-1:0]    errAddr,
  input  logic [QUAL_W-1:0]    errQual,
  input  logic                 plugReq,
  input  logic                 unplugReq,
  input  logic [SLOT_W-1:0]    hpSlot,
  input  logic                 cfgReq,
  input  logic                 cfgOn,
  input  logic [ID_W-1:0]      cfgId,
  input  logic                 popReq,
  output qStrobe_t             stb,
  output evRec_t               ent0,
  output evRec_t               ent1,
  output logic                 cfgRespValid,
  output cfgResp_t             cfgResp
);
  logic [NUM_SLOTS-1:0] populated, configured, hit;
  logic                 slotOk, doUnplug, doPlug, doErr, hitAny, curCfg;
  logic [HANDLE_W-1:0]  newHandle, curHandle;
  logic [ID_W-1:0]      newId, curId;

  assign slotOk   = (int'(hpSlot) < NUM_SLOTS);
  assign doUnplug = unplugReq && slotOk;
  assign doPlug   = plugReq && !unplugReq && slotOk;
  assign doErr    = errPush && !unplugReq && !plugReq;

  always_comb begin
    newHandle                 = '0;
    newHandle[HANDLE_W-1]     = 1'b1;
    newHandle[SLOT_W-1:0]     = hpSlot;
    newId                     = ID_W'(hpSlot);
    curHandle                 = populated[hpSlot] ? newHandle : '0;
    curId                     = populated[hpSlot] ? newId : '0;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gHit
    assign hit[g] = populated[g] && (cfgId == ID_W'(g));
  end
  assign hitAny = |hit;
  assign curCfg = |(hit & configured);

  always_comb begin
    stb    = '0;
    ent0   = '0;
    ent1   = '0;
    stb.rd = popReq;
    if (doUnplug) begin
      stb.wr0     = 1'b1;
      ent0.cls    = CLS_AVAIL;
      ent0.handle = curHandle;
      ent0.id     = curId;
      ent1        = ent0;
      ent1.status = ST_STBY_TO_RES;
      if (configured[hpSlot]) begin
        stb.wr1     = 1'b1;
        ent0.status = ST_CFG_TO_STBY;
      end else begin
        ent0.status = ST_STBY_TO_RES;
      end
    end else if (doPlug) begin
      stb.wr0     = 1'b1;
      stb.wr1     = 1'b1;
      ent0.cls    = CLS_AVAIL;
      ent0.handle = newHandle;
      ent0.id     = newId;
      ent0.status = ST_RES_TO_STBY;
      ent1        = ent0;
      ent1.status = ST_STBY_TO_CFG;
    end else if (doErr) begin
      stb.wr0     = 1'b1;
      ent0.cls    = CLS_ERR;
      ent0.status = errStatus;
      ent0.handle = errHandle;
      ent0.id     = errId;
      ent0.addr   = errAddr;
      ent0.qual   = errQual;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      populated    <= '0;
      configured   <= '0;
      cfgRespValid <= 1'b0;
      cfgResp      <= RSP_NORMAL;
    end else begin
      cfgRespValid <= cfgReq;
      if (!hitAny)              cfgResp <= RSP_UNKNOWN;
      else if (cfgOn == curCfg) cfgResp <= RSP_NOACT;
      else                      cfgResp <= RSP_NORMAL;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (doUnplug && hpSlot == SLOT_W'(s)) begin
          populated[s]  <= 1'b0;
          configured[s] <= 1'b0;
        end else if (doPlug && hpSlot == SLOT_W'(s)) begin
          populated[s]  <= 1'b1;
          configured[s] <= 1'b1;
        end else if (cfgReq && hit[s] && cfgOn != configured[s]) begin
          configured[s] <= cfgOn;
        end
      end
    end
  end

  AST_CFG_REPLY: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |=> cfgRespValid) else $error("command without response"); // R10

  AST_NOACT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && hitAny && cfgOn == curCfg && !plugReq && !unplugReq) |=> $stable(configured))
    else $error("no-action command changed state"); // R8

  AST_PAIR_LANES: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr1 |-> stb.wr0) else $error("second lane without first"); // R5

  AST_UNPLUG_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    doUnplug |=> !populated[$past(hpSlot)]) else $error("unplug left slot populated"); // R6
endmodule

// File: rtl/func_event_queue.sv
module func_event_queue
  import fevq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DEPTH     = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 errPush,
  input  logic [15:0]          errStatus,
  input  logic [31:0]          errHandle,
  input  logic [31:0]          errId,
  input  logic [63:0]          errAddr,
  input  logic [31:0]          errQual,
  input  logic                 plugReq,
  input  logic                 unplugReq,
  input  logic [SLOT_W-1:0]    hpSlot,
  input  logic                 cfgReq,
  input  logic                 cfgOn,
  input  logic [31:0]          cfgId,
  output logic                 cfgRespValid,
  output logic [1:0]           cfgResp,
  input  logic                 popReq,
  output logic                 evtPending,
  output logic                 popValid,
  output logic [1:0]           popClass,
  output logic [15:0]          popStatus,
  output logic [31:0]          popHandle,
  output logic [31:0]          popId,
  output logic [63:0]          popAddr,
  output logic [31:0]          popQual,
  output logic                 notifyPulse,
  output logic                 overflowFlag
);
  qStrobe_t stb;
  evRec_t   ent0, ent1, popRec;
  cfgResp_t respCode;

  fevq_control #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) uCtrl (
    .clk, .rstN, .errPush, .errStatus, .errHandle, .errId, .errAddr, .errQual,
    .plugReq, .unplugReq, .hpSlot, .cfgReq, .cfgOn, .cfgId, .popReq,
    .stb, .ent0, .ent1, .cfgRespValid, .cfgResp(respCode)
  );

  fevq_datapath #(.DEPTH(DEPTH)) uData (
    .clk, .rstN, .stb, .ent0, .ent1, .evtPending, .popValid, .popRec,
    .notifyPulse, .overflowFlag
  );

  assign cfgResp   = respCode;
  assign popClass  = popRec.cls;
  assign popStatus = popRec.status;
  assign popHandle = popRec.handle;
  assign popId     = popRec.id;
  assign popAddr   = popRec.addr;
  assign popQual   = popRec.qual;
endmodule

// File: tb/sim_func_event_queue.sv
`timescale 1ns/1ps
module sim_func_event_queue;
  logic clk = 1'b0, rstN = 1'b0;
  logic errPush = 0, plugReq = 0, unplugReq = 0, cfgReq = 0, cfgOn = 0, popReq = 0;
  logic [15:0] errStatus = 0;
  logic [31:0] errHandle = 0, errId = 0, errQual = 0, cfgId = 0;
  logic [63:0] errAddr = 0;
  logic [2:0]  hpSlot = 0;
  logic cfgRespValid, popValid, evtPending, notifyPulse, overflowFlag;
  logic [1:0]  cfgResp, popClass;
  logic [15:0] popStatus;
  logic [31:0] popHandle, popId, popQual;
  logic [63:0] popAddr;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  func_event_queue u0 (.*);

  // vector: op[26:24] arg[23:16] exp[15:0]; op 0 cfg on, 1 cfg off, 2 plug, 3 unplug, 4 pop
  localparam int NV = 21;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 8'd3, 16'd2},      {3'd2, 8'd3, 16'h0},      {3'd4, 8'd3, 16'h0301},
    {3'd4, 8'd3, 16'h0302},   {3'd0, 8'd3, 16'd1},      {3'd1, 8'd3, 16'd0},
    {3'd1, 8'd3, 16'd1},      {3'd0, 8'd3, 16'd0},      {3'd3, 8'd3, 16'h0},
    {3'd4, 8'd3, 16'h0303},   {3'd4, 8'd3, 16'h0304},   {3'd0, 8'd3, 16'd2},
    {3'd2, 8'd5, 16'h0},      {3'd1, 8'd5, 16'd0},      {3'd3, 8'd5, 16'h0},
    {3'd4, 8'd5, 16'h0301},   {3'd4, 8'd5, 16'h0302},   {3'd4, 8'd5, 16'h0304},
    {3'd4, 8'd0, 16'h0},      {3'd0, 8'd9, 16'd2},      {3'd0, 8'd5, 16'd2}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushErr(input logic [15:0] st, input logic [31:0] h, input logic [31:0] id,
                         input logic [63:0] a, input logic [31:0] q);
    errPush = 1; errStatus = st; errHandle = h; errId = id; errAddr = a; errQual = q;
    @(negedge clk);
    errPush = 0;
  endtask

  task automatic hp(input logic plug, input logic [2:0] s);
    hpSlot = s; plugReq = plug; unplugReq = !plug;
    @(negedge clk);
    plugReq = 0; unplugReq = 0;
  endtask

  task automatic cfgCmd(input logic on, input logic [31:0] id, input logic [1:0] exp, input string tag);
    cfgReq = 1; cfgOn = on; cfgId = id;
    @(negedge clk);
    cfgReq = 0;
    chk({tag, " cfgRespValid"}, cfgRespValid, 1);
    chk({tag, " cfgResp"}, cfgResp, exp);
  endtask

  task automatic popOne();
    popReq = 1;
    @(negedge clk);
    popReq = 0;
    chk("R1 popValid", popValid, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    doReset();
    // reset state
    chk("R1 reset evtPending", evtPending, 0);
    chk("R4 reset notify", notifyPulse, 0);
    chk("R11 reset overflow", overflowFlag, 0);
    chk("R12 reset popValid", popValid, 0);
    chk("R10 reset cfgRespValid", cfgRespValid, 0);

    // table walk: plug/unplug/configure sequences (R5..R10, R3, R7, R12)
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] arg;
      logic [15:0] exp;
      {op, arg, exp} = VEC[i];
      case (op)
        3'd0: cfgCmd(1'b1, 32'(arg), exp[1:0], "R8 R9 R10 vec cfg on");
        3'd1: cfgCmd(1'b0, 32'(arg), exp[1:0], "R8 R9 R10 vec cfg off");
        3'd2: begin hp(1'b1, arg[2:0]); chk("R4 vec plug notify", notifyPulse, 1); end
        3'd3: hp(1'b0, arg[2:0]);
        default: begin
          popOne();
          chk("R5 R6 R7 vec status", popStatus, exp);
          chk("R3 vec class", popClass, (exp == 0) ? 2'd0 : 2'd2);
          chk("R5 R6 vec id", popId, (exp == 0) ? 0 : 32'(arg));
          chk("R5 R6 vec handle", popHandle, (exp == 0) ? 0 : (32'h8000_0000 | 32'(arg)));
          chk("R3 vec addr qual", {popAddr[31:0], popQual}, 0);
        end
      endcase
    end
    chk("R12 pending after table", evtPending, 0);

    // R2 R1 R4: error records in order
    pushErr(16'h00A1, 32'h8000_0001, 32'd1, 64'h1234_5678_9ABC_DEF0, 32'h11);
    chk("R4 notify after push", notifyPulse, 1);
    chk("R1 pending after push", evtPending, 1);
    @(negedge clk);
    chk("R4 notify one cycle", notifyPulse, 0);
    pushErr(16'h00B2, 32'h8000_0002, 32'd2, 64'h0000_0000_0000_F000, 32'h22);
    pushErr(16'h00C3, 32'h0, 32'd7, 64'hFFFF_0000_0000_0001, 32'h33);
    popOne();
    chk("R2 class", popClass, 1);
    chk("R2 status", popStatus, 16'h00A1);
    chk("R2 handle", popHandle, 32'h8000_0001);
    chk("R2 id", popId, 1);
    chk("R2 addr", popAddr, 64'h1234_5678_9ABC_DEF0);
    chk("R2 qual", popQual, 32'h11);
    popOne();
    chk("R1 order second", popStatus, 16'h00B2);
    popOne();
    chk("R1 order third", popStatus, 16'h00C3);
    chk("R2 third addr", popAddr, 64'hFFFF_0000_0000_0001);
    chk("R1 empty after drain", evtPending, 0);

    // R12: empty pop leaves state unchanged
    popOne();
    chk("R12 empty class", popClass, 0);
    chk("R12 empty fields", {popStatus, popHandle, popQual}, 0);
    chk("R12 empty pending", evtPending, 0);
    chk("R12 empty overflow", overflowFlag, 0);

    // R11: fill, overflow drop, sticky flag
    for (int i = 0; i < 16; i++) pushErr(16'h0E00, 0, 0, 0, 32'(i));
    chk("R11 no overflow at 16", overflowFlag, 0);
    pushErr(16'h0E00, 0, 0, 0, 32'd99);
    chk("R11 overflow set", overflowFlag, 1);
    chk("R4 no notify on drop", notifyPulse, 0);
    for (int i = 0; i < 16; i++) begin
      popOne();
      chk("R11 kept records", popQual, 32'(i));
    end
    popOne();
    chk("R11 dropped record absent", popClass, 0);
    chk("R11 overflow sticky", overflowFlag, 1);

    // R11: pair with one free place
    doReset();
    chk("R11 overflow cleared by reset", overflowFlag, 0);
    for (int i = 0; i < 15; i++) pushErr(16'h0F00, 0, 0, 0, 32'(i));
    hp(1'b1, 3'd1);
    chk("R11 pair overflow", overflowFlag, 1);
    for (int i = 0; i < 16; i++) begin
      popOne();
      if (i == 15) begin
        chk("R11 pair first kept", popStatus, 16'h0301);
        chk("R11 pair first class", popClass, 2);
      end
    end
    popOne();
    chk("R11 pair second dropped", popClass, 0);
    cfgCmd(1'b1, 32'd1, 2'd1, "R5 plugged slot configured");

    // R13: plug beats error push
    hpSlot = 3'd6; plugReq = 1; errPush = 1; errStatus = 16'h0BAD;
    @(negedge clk);
    plugReq = 0; errPush = 0;
    popOne();
    chk("R13 plug first", popStatus, 16'h0301);
    popOne();
    chk("R13 plug second", popStatus, 16'h0302);
    popOne();
    chk("R13 error ignored", popClass, 0);
    // R13 R7: unplug beats plug on an empty slot
    hpSlot = 3'd2; plugReq = 1; unplugReq = 1;
    @(negedge clk);
    plugReq = 0; unplugReq = 0;
    popOne();
    chk("R13 R7 unplug only status", popStatus, 16'h0304);
    chk("R7 empty slot handle", popHandle, 0);
    chk("R7 empty slot id", popId, 0);
    popOne();
    chk("R13 single record", popClass, 0);
    cfgCmd(1'b1, 32'd2, 2'd2, "R13 plug ignored");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule